// File: doc/BRIEF.md
# AES3 Receive Status and Non-Audio Burst Detector

This block sits behind a biphase decoder on a digital audio receive path. The decoder delivers one subframe per strobe. Each subframe carries its preamble type, 24 audio bits, the validity, user, channel-status and parity bits, and a flag for a coding violation. A separate level input reports whether clock recovery has lost lock.

From these inputs the block keeps a set of registered status flags: parity error, coding error, validity, unlock, and a confidence flag derived from coding and lock. A one-cycle error pulse fires when an enabled flag first goes high. The audio sample is passed downstream one cycle after its strobe. When the sample was damaged, a selectable policy decides what goes out instead: the last clean sample of the same channel, zero, or the damaged sample unchanged.

The block also scans the upper 16 audio bits of successive subframes for the six-word burst sync sequence that marks a compressed (non-audio) payload. When the sequence is seen, it raises a sticky non-audio indication that drops after a long run of frames with no new sync.

Top module: `aes_rx_status`

## Requirements
- R1: `flag_par` is updated at every strobe. It becomes 1 when the XOR of the 28 bits {audio[23:0], V, U, C, P} is 1 (even parity fails) and 0 otherwise. Between strobes it holds its value.
- R2: `flag_bip` takes the value of `sf_bip` at every strobe and holds it between strobes.
- R3: `flag_v` takes the value of the V bit of the most recent subframe.
- R4: `flag_unlock` follows `pll_unlock` with one cycle of delay. `flag_conf` is always the OR of `flag_bip` and `flag_unlock`.
- R5: `err_pulse` is high for one cycle, in the same cycle that a flag first reads 1, when that flag's bit in `err_en` is set. The bits are: bit0 parity, bit1 coding, bit2 confidence, bit3 validity, bit4 unlock. A flag that rises while its enable bit is clear produces no pulse, and a flag that stays at 1 produces no further pulse.
- R6: `out_valid` is high for exactly the one cycle after each strobe. At that time `out_chan` is 1 for a right-channel subframe (preamble code 2) and 0 for codes 0 and 1. A sample with neither a parity error nor a coding error passes unchanged in every policy.
- R7: Policy code 2'b10 and the reserved code 2'b11 pass a damaged sample unchanged. A damaged sample is one with a parity or coding error.
- R8: Policy code 2'b01 outputs zero in place of a damaged sample.
- R9: Policy code 2'b00 outputs the last clean sample of the same channel in place of a damaged sample. That value is zero if no clean sample has arrived since reset.
- R10: `nonaudio` rises at the strobe that completes six consecutive subframes whose audio[23:8] are 0x0000, 0x0000, 0x0000, 0x0000, 0xF872, 0x4E1F. A wrong word restarts the search. A zero word that arrives where 0xF872 is expected keeps the search waiting for 0xF872.
- R11: Once set, `nonaudio` stays 1 until TIMEOUT_FRAMES (default 4096) left-channel strobes have passed with no new sync. It clears at the strobe that completes that count. A new sync restarts the count.
- R12: After reset, all flags, `err_pulse`, `out_valid`, `out_audio` and `nonaudio` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sf_valid | input | 1 | One-cycle strobe: a decoded subframe is present |
| sf_pre | input | 2 | Preamble type: 0 block start (left), 1 left, 2 right |
| sf_audio | input | 24 | Audio payload bits |
| sf_v | input | 1 | Validity bit |
| sf_u | input | 1 | User bit |
| sf_c | input | 1 | Channel-status bit |
| sf_p | input | 1 | Parity bit |
| sf_bip | input | 1 | Coding violation seen in this subframe |
| pll_unlock | input | 1 | Clock recovery not locked |
| err_en | input | 5 | Per-flag enable for the error pulse |
| hold_mode | input | 2 | Damaged-sample policy |
| flag_par | output | 1 | Parity error on the last subframe |
| flag_bip | output | 1 | Coding error on the last subframe |
| flag_conf | output | 1 | Confidence error |
| flag_v | output | 1 | Validity bit of the last subframe |
| flag_unlock | output | 1 | Registered unlock state |
| err_pulse | output | 1 | One-cycle pulse on an enabled flag rising |
| out_valid | output | 1 | Output sample strobe |
| out_chan | output | 1 | Output sample channel, 1 = right |
| out_audio | output | 24 | Output sample after the policy |
| nonaudio | output | 1 | Burst sync seen recently |

## Verification
The bench feeds damaged samples under each policy and alternates channels. A design that kept one shared last-good register would return the other channel's sample under code 00. The burst tests feed a near miss that breaks at the final word, and a run of five zeros before 0xF872. A detector that restarted on any mismatch would miss the second pattern. The timeout test checks `nonaudio` one frame before the limit and again at the limit, which exposes an off-by-one counter. The pulse tests hold a flag at 1 across two damaged subframes and then mask it, so an edge detector that pulsed on level or ignored the enable would show up.

// File: rtl/aes_rx_pkg.sv
package aes_rx_pkg;
  localparam int NFLAG = 5;
  localparam int F_PAR = 0;
  localparam int F_BIP = 1;
  localparam int F_CONF = 2;
  localparam int F_V = 3;
  localparam int F_UNLOCK = 4;

  typedef enum logic [1:0] {
    PRE_BLOCK = 2'd0,
    PRE_LEFT  = 2'd1,
    PRE_RIGHT = 2'd2
  } pre_t;

  typedef enum logic [1:0] {
    POL_LAST = 2'b00,
    POL_ZERO = 2'b01,
    POL_PASS = 2'b10,
    POL_RSVD = 2'b11
  } policy_t;

  localparam int SYNC_LEN = 6;

  function automatic logic [15:0] sync_word(input int idx);
    case (idx)
      4:       return 16'hF872;
      5:       return 16'h4E1F;
      default: return 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/aes_rx_flags.sv
module aes_rx_flags
  import aes_rx_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sf_valid,
  input  logic [DATA_W-1:0] sf_audio,
  input  logic              sf_v,
  input  logic              sf_u,
  input  logic              sf_c,
  input  logic              sf_p,
  input  logic              sf_bip,
  input  logic              pll_unlock,
  input  logic [NFLAG-1:0]  err_en,
  output logic              sample_bad,
  output logic [NFLAG-1:0]  flags_q,
  output logic              err_pulse
);
  logic par_odd;
  logic [NFLAG-1:0] flags_d;

  always_comb begin
    par_odd = ^{sf_audio, sf_v, sf_u, sf_c, sf_p};
    sample_bad = par_odd | sf_bip;
    flags_d = flags_q;
    if (sf_valid) begin
      flags_d[F_PAR] = par_odd;
      flags_d[F_BIP] = sf_bip;
      flags_d[F_V]   = sf_v;
    end
    flags_d[F_UNLOCK] = pll_unlock;
    flags_d[F_CONF]   = flags_d[F_BIP] | pll_unlock;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q   <= '0;
      err_pulse <= 1'b0;
    end else begin
      flags_q   <= flags_d;
      err_pulse <= |(flags_d & ~flags_q & err_en);
    end
  end

  // R1 R2: per-subframe flags hold between strobes
  a_r1_par_holds: assert property (@(posedge clk) disable iff (rst)
    !sf_valid |=> $stable(flags_q[F_PAR]));
  a_r2_bip_holds: assert property (@(posedge clk) disable iff (rst)
    !sf_valid |=> $stable(flags_q[F_BIP]));
  // R4: confidence is the OR of coding and unlock flags
  a_r4_conf_or: assert property (@(posedge clk) disable iff (rst)
    flags_q[F_CONF] == (flags_q[F_BIP] | flags_q[F_UNLOCK]));
  // R5: a pulse always has an enabled flag that is high
  a_r5_pulse_cause: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> ((flags_q & err_en) != '0));
endmodule

// File: rtl/aes_rx_hold.sv
module aes_rx_hold
  import aes_rx_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int NCHAN  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sf_valid,
  input  logic [$clog2(NCHAN)-1:0] sf_chan,
  input  logic [DATA_W-1:0]        sf_audio,
  input  logic                     sample_bad,
  input  logic [1:0]               hold_mode,
  output logic                     out_valid,
  output logic [$clog2(NCHAN)-1:0] out_chan,
  output logic [DATA_W-1:0]        out_audio
);
  localparam int CW = $clog2(NCHAN);

  logic [DATA_W-1:0] keep_q [NCHAN];
  logic [DATA_W-1:0] pick;
  logic              bad_q;
  logic [1:0]        mode_q;

  always_comb begin
    pick = sf_audio;
    if (sample_bad) begin
      unique case (policy_t'(hold_mode))
        POL_LAST: pick = keep_q[sf_chan];
        POL_ZERO: pick = '0;
        default:  pick = sf_audio;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCHAN; c++) keep_q[c] <= '0;
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_audio <= '0;
      bad_q     <= 1'b0;
      mode_q    <= 2'b00;
    end else begin
      out_valid <= sf_valid;
      if (sf_valid) begin
        out_chan  <= sf_chan;
        out_audio <= pick;
        bad_q     <= sample_bad;
        mode_q    <= hold_mode;
        for (int c = 0; c < NCHAN; c++)
          if (sf_chan == CW'(c) && !sample_bad) keep_q[c] <= sf_audio;
      end
    end
  end

  // R6: one output strobe per input strobe, one cycle later
  a_r6_strobe: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(sf_valid));
  // R8: zero policy on a damaged sample yields zero
  a_r8_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && bad_q && mode_q == POL_ZERO) |-> out_audio == '0);
endmodule

// File: rtl/aes_rx_burst.sv
module aes_rx_burst
  import aes_rx_pkg::*;
#(
  parameter int DATA_W         = 24,
  parameter int WORD_W         = 16,
  parameter int TIMEOUT_FRAMES = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sf_valid,
  input  logic              sf_right,
  input  logic [DATA_W-1:0] sf_audio,
  output logic              nonaudio
);
  localparam int IW    = $clog2(SYNC_LEN + 1);
  localparam int CNT_W = $clog2(TIMEOUT_FRAMES);
  localparam int ZERO_SLOT = 4;

  logic [WORD_W-1:0] word;
  logic [IW-1:0]     idx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              hit, complete, frame_tick;
  logic [WORD_W-1:0] want;

  always_comb begin
    word = sf_audio[DATA_W-1 -: WORD_W];
    want = sync_word(int'(idx_q));
    hit = (word == want);
    complete = sf_valid && hit && (idx_q == IW'(SYNC_LEN - 1));
    frame_tick = sf_valid && !sf_right;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      cnt_q    <= '0;
      nonaudio <= 1'b0;
    end else begin
      if (sf_valid) begin
        if (complete)              idx_q <= '0;
        else if (hit)              idx_q <= idx_q + 1'b1;
        else if (word == '0)       idx_q <= (idx_q == IW'(ZERO_SLOT)) ? IW'(ZERO_SLOT) : IW'(1);
        else                       idx_q <= '0;
      end
      if (complete) begin
        nonaudio <= 1'b1;
        cnt_q    <= '0;
      end else if (nonaudio && frame_tick) begin
        if (cnt_q == CNT_W'(TIMEOUT_FRAMES - 1)) begin
          nonaudio <= 1'b0;
          cnt_q    <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R10: search index stays inside the sequence
  a_r10_idx_range: assert property (@(posedge clk) disable iff (rst)
    idx_q < IW'(SYNC_LEN));
  a_r10_rise_on_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(nonaudio) |-> $past(sf_valid));
  // R11: detection only drops on a left-channel strobe
  a_r11_fall_on_frame: assert property (@(posedge clk) disable iff (rst)
    $fell(nonaudio) |-> ($past(sf_valid) && !$past(sf_right)));
endmodule

// File: rtl/aes_rx_status.sv
module aes_rx_status
  import aes_rx_pkg::*;
#(
  parameter int DATA_W         = 24,
  parameter int WORD_W         = 16,
  parameter int TIMEOUT_FRAMES = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sf_valid,
  input  logic [1:0]        sf_pre,
  input  logic [DATA_W-1:0] sf_audio,
  input  logic              sf_v,
  input  logic              sf_u,
  input  logic              sf_c,
  input  logic              sf_p,
  input  logic              sf_bip,
  input  logic              pll_unlock,
  input  logic [4:0]        err_en,
  input  logic [1:0]        hold_mode,
  output logic              flag_par,
  output logic              flag_bip,
  output logic              flag_conf,
  output logic              flag_v,
  output logic              flag_unlock,
  output logic              err_pulse,
  output logic              out_valid,
  output logic              out_chan,
  output logic [DATA_W-1:0] out_audio,
  output logic              nonaudio
);
  logic             is_right;
  logic             sample_bad;
  logic [NFLAG-1:0] flags;

  assign is_right = (sf_pre == PRE_RIGHT);

  aes_rx_flags #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst(rst), .sf_valid(sf_valid), .sf_audio(sf_audio),
    .sf_v(sf_v), .sf_u(sf_u), .sf_c(sf_c), .sf_p(sf_p), .sf_bip(sf_bip),
    .pll_unlock(pll_unlock), .err_en(err_en), .sample_bad(sample_bad),
    .flags_q(flags), .err_pulse(err_pulse)
  );

  aes_rx_hold #(.DATA_W(DATA_W), .NCHAN(2)) u_hold (
    .clk(clk), .rst(rst), .sf_valid(sf_valid), .sf_chan(is_right),
    .sf_audio(sf_audio), .sample_bad(sample_bad), .hold_mode(hold_mode),
    .out_valid(out_valid), .out_chan(out_chan), .out_audio(out_audio)
  );

  aes_rx_burst #(.DATA_W(DATA_W), .WORD_W(WORD_W), .TIMEOUT_FRAMES(TIMEOUT_FRAMES)) u_burst (
    .clk(clk), .rst(rst), .sf_valid(sf_valid), .sf_right(is_right),
    .sf_audio(sf_audio), .nonaudio(nonaudio)
  );

  assign flag_par    = flags[F_PAR];
  assign flag_bip    = flags[F_BIP];
  assign flag_conf   = flags[F_CONF];
  assign flag_v      = flags[F_V];
  assign flag_unlock = flags[F_UNLOCK];

  // R4: unlock flag trails the input by one cycle
  a_r4_unlock_follow: assert property (@(posedge clk) disable iff (rst)
    flag_unlock == $past(pll_unlock));
  // R3: validity flag only moves on a strobe
  a_r3_v_holds: assert property (@(posedge clk) disable iff (rst)
    !sf_valid |=> $stable(flag_v));
endmodule

// File: tb/aes_rx_status_bench.sv
module aes_rx_status_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sf_valid = 1'b0;
  logic [1:0]  sf_pre = 2'd0;
  logic [23:0] sf_audio = '0;
  logic        sf_v = 1'b0, sf_u = 1'b0, sf_c = 1'b0, sf_p = 1'b0, sf_bip = 1'b0;
  logic        pll_unlock = 1'b0;
  logic [4:0]  err_en = 5'h1F;
  logic [1:0]  hold_mode = 2'b10;
  logic        flag_par, flag_bip, flag_conf, flag_v, flag_unlock, err_pulse;
  logic        out_valid, out_chan, nonaudio;
  logic [23:0] out_audio;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  aes_rx_status u_aes_rx_status (
    .clk(clk), .rst(rst), .sf_valid(sf_valid), .sf_pre(sf_pre), .sf_audio(sf_audio),
    .sf_v(sf_v), .sf_u(sf_u), .sf_c(sf_c), .sf_p(sf_p), .sf_bip(sf_bip),
    .pll_unlock(pll_unlock), .err_en(err_en), .hold_mode(hold_mode),
    .flag_par(flag_par), .flag_bip(flag_bip), .flag_conf(flag_conf), .flag_v(flag_v),
    .flag_unlock(flag_unlock), .err_pulse(err_pulse), .out_valid(out_valid),
    .out_chan(out_chan), .out_audio(out_audio), .nonaudio(nonaudio)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one subframe; returns at the next falling edge, outputs already updated
  task automatic send(input bit right, input logic [23:0] aud, input bit v,
                      input bit bad_par, input bit bip);
    sf_valid = 1'b1;
    sf_pre   = right ? 2'd2 : 2'd1;
    sf_audio = aud;
    sf_v     = v;
    sf_u     = 1'b0;
    sf_c     = 1'b0;
    sf_bip   = bip;
    sf_p     = (^{aud, v, 1'b0, 1'b0}) ^ bad_par;
    @(negedge clk);
    sf_valid = 1'b0;
    sf_bip   = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R12 flags", {27'd0, flag_par, flag_bip, flag_conf, flag_v, flag_unlock}, 32'd0);
    chk("R12 outs", {29'd0, err_pulse, out_valid, nonaudio}, 32'd0);
    chk("R12 audio", {8'd0, out_audio}, 32'd0);
  endtask

  task automatic t_flags();
    send(0, 24'h123456, 0, 0, 0);
    chk("R1 clean parity", {31'd0, flag_par}, 32'd0);
    chk("R6 out_valid", {31'd0, out_valid}, 32'd1);
    idle();
    chk("R6 out_valid drops", {31'd0, out_valid}, 32'd0);
    send(0, 24'h0F0F0F, 0, 1, 0);
    chk("R1 odd parity", {31'd0, flag_par}, 32'd1);
    idle();
    chk("R1 holds", {31'd0, flag_par}, 32'd1);
    send(1, 24'h000001, 0, 0, 1);
    chk("R2 bip set", {31'd0, flag_bip}, 32'd1);
    chk("R4 conf from bip", {31'd0, flag_conf}, 32'd1);
    chk("R6 out_chan right", {31'd0, out_chan}, 32'd1);
    send(0, 24'h000002, 1, 0, 0);
    chk("R3 V set", {31'd0, flag_v}, 32'd1);
    chk("R2 bip cleared", {31'd0, flag_bip}, 32'd0);
    send(0, 24'h000003, 0, 0, 0);
    chk("R3 V cleared", {31'd0, flag_v}, 32'd0);
    chk("R4 conf cleared", {31'd0, flag_conf}, 32'd0);
  endtask

  task automatic t_unlock();
    pll_unlock = 1'b1;
    @(negedge clk);
    chk("R4 unlock follows", {31'd0, flag_unlock}, 32'd1);
    chk("R4 conf from unlock", {31'd0, flag_conf}, 32'd1);
    pll_unlock = 1'b0;
    @(negedge clk);
    chk("R4 unlock clears", {30'd0, flag_unlock, flag_conf}, 32'd0);
  endtask

  task automatic t_pulse();
    err_en = 5'b00001;
    send(0, 24'h000010, 0, 1, 0);
    chk("R5 pulse on rise", {31'd0, err_pulse}, 32'd1);
    idle();
    chk("R5 pulse one cycle", {31'd0, err_pulse}, 32'd0);
    send(0, 24'h000011, 0, 1, 0);
    chk("R5 no pulse while high", {31'd0, err_pulse}, 32'd0);
    send(0, 24'h000012, 0, 0, 0);
    err_en = 5'b11110;
    send(0, 24'h000013, 0, 1, 0);
    chk("R5 masked flag set", {31'd0, flag_par}, 32'd1);
    chk("R5 masked no pulse", {31'd0, err_pulse}, 32'd0);
    send(0, 24'h000014, 1, 0, 0);
    chk("R5 V enabled pulse", {31'd0, err_pulse}, 32'd1);
    send(0, 24'h000015, 0, 0, 0);
    err_en = 5'h1F;
  endtask

  task automatic t_policy();
    hold_mode = 2'b10;
    send(0, 24'hABCDEF, 0, 1, 0);
    chk("R7 pass damaged", {8'd0, out_audio}, {8'd0, 24'hABCDEF});
    hold_mode = 2'b11;
    send(1, 24'h13579B, 0, 0, 1);
    chk("R7 reserved passes", {8'd0, out_audio}, {8'd0, 24'h13579B});
    hold_mode = 2'b01;
    send(0, 24'h777777, 0, 1, 0);
    chk("R8 zero damaged", {8'd0, out_audio}, 32'd0);
    send(0, 24'h654321, 0, 0, 0);
    chk("R6 clean passes under 01", {8'd0, out_audio}, {8'd0, 24'h654321});
    hold_mode = 2'b00;
    send(0, 24'h111111, 0, 0, 0);
    chk("R6 clean passes under 00", {8'd0, out_audio}, {8'd0, 24'h111111});
    send(1, 24'h222222, 0, 0, 0);
    send(0, 24'h333333, 0, 1, 0);
    chk("R9 left holds last left", {8'd0, out_audio}, {8'd0, 24'h111111});
    send(1, 24'h444444, 0, 0, 1);
    chk("R9 right holds last right", {8'd0, out_audio}, {8'd0, 24'h222222});
    chk("R6 chan of held", {31'd0, out_chan}, 32'd1);
    hold_mode = 2'b10;
  endtask

  task automatic t_sync();
    logic [15:0] miss [6];
    logic [15:0] good [6];
    miss = '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'hF872, 16'h1234};
    good = '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'hF872, 16'h4E1F};
    for (int i = 0; i < 6; i++) send(i[0], {miss[i], 8'h00}, 0, 0, 0);
    chk("R10 near miss no detect", {31'd0, nonaudio}, 32'd0);
    send(0, {16'h0000, 8'h00}, 0, 0, 0);
    for (int i = 0; i < 5; i++) begin
      send(~i[0], {good[i], 8'h00}, 0, 0, 0);
      if (i == 4) chk("R10 not before last word", {31'd0, nonaudio}, 32'd0);
    end
    send(0, {good[5], 8'h00}, 0, 0, 0);
    chk("R10 detect after zero run", {31'd0, nonaudio}, 32'd1);
  endtask

  task automatic t_timeout();
    // sync completed on a left strobe; now count left strobes
    for (int i = 0; i < 4095; i++) begin
      send(1, 24'h123400, 0, 0, 0);
      send(0, 24'h123400, 0, 0, 0);
    end
    send(1, 24'h123400, 0, 0, 0);
    chk("R11 held one short", {31'd0, nonaudio}, 32'd1);
    send(0, 24'h123400, 0, 0, 0);
    chk("R11 cleared at limit", {31'd0, nonaudio}, 32'd0);
    for (int i = 0; i < 6; i++) send(i[0], {(i == 4) ? 16'hF872 : (i == 5) ? 16'h4E1F : 16'h0000, 8'h00}, 0, 0, 0);
    chk("R10 redetect", {31'd0, nonaudio}, 32'd1);
    for (int i = 0; i < 100; i++) send(0, 24'h123400, 0, 0, 0);
    chk("R11 still held mid window", {31'd0, nonaudio}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_flags();
    t_unlock();
    t_pulse();
    t_policy();
    t_sync();
    t_timeout();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule